// File: doc/BRIEF.md
# One-Time-Programmable Identification Region

This block holds a 256-bit identification area split into two parts. The low 64 bits are fixed when the design is built and can never be altered. The upper 192 bits start fully erased (all ones) and can be programmed once by the user. Programming can only clear bits, and nothing in the block can set a cleared bit back to one. A lock command permanently freezes the whole region against further programming. A sticky `locked` flag reports that state to the surrounding status logic.

Requests arrive on a single byte-offset bus. In any cycle a caller may issue a program request (one data byte), a read request, a lock request, or several of them together. Reads return one byte on the following cycle. A program request that the block refuses produces a one-cycle error pulse and does not change storage. The user segment is kept in a memory with one write port and two synchronous read ports, so it suits FPGA RAM. Clearing bits is done by a two-stage read-modify-write with bypass, and the caller never sees that pipeline.

Top module: `otp_id_region`

## Requirements
- R1: A read of offset k in 0..7 returns bits [8k+7:8k] of the build-time parameter `PRESET_ID` on `rd_data` in the next cycle, and these bytes never change.
- R2: A program request to any offset in 0..7 is refused: `prog_err` pulses in the next cycle and the preset bytes keep their values.
- R3: After power-up, every byte at offsets 8..31 reads 0xFF until it is programmed.
- R4: An accepted program to offset k in 8..31 stores old AND `wr_data`. A read requested in the same cycle as the program returns the old byte. Reads requested in any later cycle return the new byte, including after back-to-back programs to the same offset.
- R5: A `lock_req` sampled outside reset makes `locked` high from the next cycle onward. Once high, `locked` never falls, and a reset does not clear it.
- R6: While `locked` is high, every program request to offsets 0..31 is refused and leaves storage unchanged. A program sampled in the same cycle as the `lock_req` that sets the lock is judged as unlocked.
- R7: Offsets 32 and above are ignored. A read there gives no `rd_valid`, and a program there gives no `prog_err` and changes nothing.
- R8: `prog_err` is high for exactly one cycle after each refused program request and low in every other cycle.
- R9: A read of offsets 0..31 raises `rd_valid` in the next cycle whether the region is locked or not. `rd_data` is 0 whenever `rd_valid` is low.
- R10: Reset is synchronous and active high. In the cycle after an edge with `rst` high, `rd_valid`, `rd_data` and `prog_err` are 0. Requests sampled while `rst` is high are ignored, and stored bytes keep their values.
- R11: No stored bit ever returns from 0 to 1. Programming a byte with 0xFF leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the request and output logic |
| prog_req | input | 1 | Program the byte at `addr` with `wr_data` (AND into old value) |
| lock_req | input | 1 | Permanently freeze the region against programming |
| rd_req | input | 1 | Read the byte at `addr` |
| addr | input | ADDR_W (6) | Byte offset shared by read and program requests |
| wr_data | input | BYTE_W (8) | Program data byte |
| rd_data | output | BYTE_W (8) | Read data, valid with `rd_valid`, else 0 |
| rd_valid | output | 1 | Read result present this cycle |
| prog_err | output | 1 | One-cycle pulse for a refused program request |
| locked | output | 1 | Sticky lock status flag |

## Verification
The reference model predicts every output on every clock. A wrong stored byte therefore shows up on the first read of that offset, one cycle after the read request. A missed bypass in the read-modify-write pipeline shows up as a stale byte on a read issued right after a program to the same offset, or as the wrong value after two back-to-back programs. A wrong lock state shows up directly on `locked`, and also as a missing or spurious `prog_err` on the cycle after the next program request. The sequences deliberately place a read and a program in the same cycle, a lock and a program in the same cycle, and a reset after a lock, because those are the cycles where such faults show.

// File: rtl/otp_id_pkg.sv
package otp_id_pkg;

  // Outcome of a program request once it has been checked against the region rules
  typedef enum logic [1:0] {
    PV_IGNORE = 2'd0,
    PV_ACCEPT = 2'd1,
    PV_REFUSE = 2'd2
  } prog_verdict_e;

  // Where the byte returned by a read request comes from
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_PRESET = 2'd1,
    SRC_USER   = 2'd2
  } read_src_e;

endpackage

// File: rtl/otp_req_decode.sv
module otp_req_decode
  import otp_id_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int TOTAL_BYTES  = 32,
  parameter int PRESET_BYTES = 8
) (
  input  logic              rst,
  input  logic              prog_req,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              locked,
  output prog_verdict_e     verdict,
  output read_src_e         rd_src
);

  logic in_range;
  logic in_preset;

  always_comb begin
    in_range  = 32'(addr) < 32'(TOTAL_BYTES);
    in_preset = 32'(addr) < 32'(PRESET_BYTES);

    if (rst || !prog_req || !in_range) begin
      verdict = PV_IGNORE;
    end else if (in_preset || locked) begin
      verdict = PV_REFUSE;
    end else begin
      verdict = PV_ACCEPT;
    end

    if (rst || !rd_req || !in_range) begin
      rd_src = SRC_NONE;
    end else if (in_preset) begin
      rd_src = SRC_PRESET;
    end else begin
      rd_src = SRC_USER;
    end
  end

endmodule

// File: rtl/otp_lock_reg.sv
module otp_lock_reg (
  input  logic clk,
  input  logic rst,
  input  logic lock_req,
  output logic locked
);

  // Non-volatile state: set once by configuration-time init, never cleared by rst
  logic lock_q = 1'b0;

  always_ff @(posedge clk) begin
    if (lock_req && !rst) begin
      lock_q <= 1'b1;
    end
  end

  assign locked = lock_q;

endmodule

// File: rtl/otp_user_array.sv
module otp_user_array #(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 24,
  parameter int IDX_W  = 5,
  parameter int NRD    = 2
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [BYTE_W-1:0]            wr_val,
  input  logic [NRD-1:0]               rd_en,
  input  logic [NRD-1:0][IDX_W-1:0]    rd_idx,
  output logic [NRD-1:0][BYTE_W-1:0]   rd_val
);

  logic [BYTE_W-1:0] mem [DEPTH];

  // Erased state of the user segment, applied at configuration time only
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_val;
    end
  end

  // Each read port is read-first; a write to the same word at the same edge is
  // captured alongside and wins, so a caller sees the newest value.
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic [BYTE_W-1:0] q;
    logic [BYTE_W-1:0] fwd;
    logic              hit;

    always_ff @(posedge clk) begin
      if (rd_en[g]) begin
        q   <= mem[rd_idx[g]];
        fwd <= wr_val;
        hit <= wr_en && (wr_idx == rd_idx[g]);
      end
    end

    assign rd_val[g] = hit ? fwd : q;
  end

endmodule

// File: rtl/otp_id_region.sv
module otp_id_region
  import otp_id_pkg::*;
#(
  parameter int                                BYTE_W       = 8,
  parameter int                                TOTAL_BYTES  = 32,
  parameter int                                PRESET_BYTES = 8,
  parameter int                                ADDR_W       = 6,
  parameter logic [PRESET_BYTES*BYTE_W-1:0]    PRESET_ID    = 64'hC3A5_1E0F_7D92_4B68
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_req,
  input  logic              lock_req,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              prog_err,
  output logic              locked
);

  localparam int USER_BYTES = TOTAL_BYTES - PRESET_BYTES;
  localparam int UIDX_W     = (USER_BYTES > 1) ? $clog2(USER_BYTES) : 1;
  localparam int PIDX_W     = (PRESET_BYTES > 1) ? $clog2(PRESET_BYTES) : 1;
  localparam int RMW_PORT   = 0;
  localparam int RD_PORT    = 1;

  prog_verdict_e verdict;
  read_src_e     rd_src;
  logic          lock_st;

  otp_req_decode #(
    .ADDR_W      (ADDR_W),
    .TOTAL_BYTES (TOTAL_BYTES),
    .PRESET_BYTES(PRESET_BYTES)
  ) u_dec (
    .rst     (rst),
    .prog_req(prog_req),
    .rd_req  (rd_req),
    .addr    (addr),
    .locked  (lock_st),
    .verdict (verdict),
    .rd_src  (rd_src)
  );

  otp_lock_reg u_lock (
    .clk     (clk),
    .rst     (rst),
    .lock_req(lock_req),
    .locked  (lock_st)
  );

  // Preset segment: constant bytes sliced out of the build-time parameter
  logic [BYTE_W-1:0] preset_rom [PRESET_BYTES];
  for (genvar g = 0; g < PRESET_BYTES; g++) begin : g_rom
    assign preset_rom[g] = PRESET_ID[g*BYTE_W +: BYTE_W];
  end

  logic [UIDX_W-1:0] uidx;
  logic [PIDX_W-1:0] pidx;
  assign uidx = UIDX_W'(addr - ADDR_W'(PRESET_BYTES));
  assign pidx = addr[PIDX_W-1:0];

  // Read-modify-write stage: old byte arrives one cycle after acceptance
  logic              st_v;
  logic [UIDX_W-1:0] st_idx;
  logic [BYTE_W-1:0] st_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_v <= 1'b0;
    end else begin
      st_v <= (verdict == PV_ACCEPT);
    end
    st_idx  <= uidx;
    st_data <= wr_data;
  end

  logic [1:0]             arr_rd_en;
  logic [1:0][UIDX_W-1:0] arr_rd_idx;
  logic [1:0][BYTE_W-1:0] arr_rd_val;
  logic [BYTE_W-1:0]      wr_val;

  assign arr_rd_en[RMW_PORT]  = (verdict == PV_ACCEPT);
  assign arr_rd_en[RD_PORT]   = (rd_src == SRC_USER);
  assign arr_rd_idx[RMW_PORT] = uidx;
  assign arr_rd_idx[RD_PORT]  = uidx;
  assign wr_val = arr_rd_val[RMW_PORT] & st_data;

  otp_user_array #(
    .BYTE_W(BYTE_W),
    .DEPTH (USER_BYTES),
    .IDX_W (UIDX_W),
    .NRD   (2)
  ) u_arr (
    .clk   (clk),
    .wr_en (st_v),
    .wr_idx(st_idx),
    .wr_val(wr_val),
    .rd_en (arr_rd_en),
    .rd_idx(arr_rd_idx),
    .rd_val(arr_rd_val)
  );

  // Output registers
  logic              rd_valid_q;
  logic              src_user_q;
  logic [BYTE_W-1:0] pre_q;
  logic              err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      src_user_q <= 1'b0;
      pre_q      <= '0;
      err_q      <= 1'b0;
    end else begin
      rd_valid_q <= (rd_src != SRC_NONE);
      src_user_q <= (rd_src == SRC_USER);
      pre_q      <= preset_rom[pidx];
      err_q      <= (verdict == PV_REFUSE);
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = !rd_valid_q ? '0 : (src_user_q ? arr_rd_val[RD_PORT] : pre_q);
  assign prog_err = err_q;
  assign locked   = lock_st;

endmodule

// File: rtl/otp_id_region_chk.sv
module otp_id_region_chk #(
  parameter int                             BYTE_W       = 8,
  parameter int                             TOTAL_BYTES  = 32,
  parameter int                             PRESET_BYTES = 8,
  parameter int                             ADDR_W       = 6,
  parameter logic [PRESET_BYTES*BYTE_W-1:0] PRESET_ID    = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              prog_req,
  input logic              lock_req,
  input logic              rd_req,
  input logic [ADDR_W-1:0] addr,
  input logic [BYTE_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              prog_err,
  input logic              locked
);

  // R1
  preset_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req && (32'(addr) < 32'(PRESET_BYTES)) |=>
      rd_valid && (rd_data == BYTE_W'(PRESET_ID >> (BYTE_W * int'($past(addr))))));

  // R2
  preset_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    prog_req && (32'(addr) < 32'(PRESET_BYTES)) |=> prog_err);

  // R5
  lock_set_chk: assert property (@(posedge clk) disable iff (rst)
    lock_req |=> locked);

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  // R6
  locked_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    prog_req && locked && (32'(addr) < 32'(TOTAL_BYTES)) |=> prog_err);

  // R7
  out_of_range_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req || prog_req) && (32'(addr) >= 32'(TOTAL_BYTES)) |=> !rd_valid && !prog_err);

  // R8
  err_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    !prog_req |=> !prog_err);

  // R8
  accept_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    prog_req && !locked && (32'(addr) >= 32'(PRESET_BYTES)) |=> !prog_err);

  // R9
  read_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req && (32'(addr) < 32'(TOTAL_BYTES)) |=> rd_valid);

  // R9
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_data == '0));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !rd_valid && !prog_err && (rd_data == '0));

endmodule

bind otp_id_region otp_id_region_chk #(
  .BYTE_W      (BYTE_W),
  .TOTAL_BYTES (TOTAL_BYTES),
  .PRESET_BYTES(PRESET_BYTES),
  .ADDR_W      (ADDR_W),
  .PRESET_ID   (PRESET_ID)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .prog_req(prog_req),
  .lock_req(lock_req),
  .rd_req  (rd_req),
  .addr    (addr),
  .rd_data (rd_data),
  .rd_valid(rd_valid),
  .prog_err(prog_err),
  .locked  (locked)
);

// File: tb/sim_otp_id_region.sv
module sim_otp_id_region;

  localparam int          CLK_PERIOD = 10;
  localparam logic [63:0] PRESET     = 64'h5A17_E3C0_9B24_D86F;

  logic       clk = 1'b0;
  logic       rst, prog_req, lock_req, rd_req;
  logic [5:0] addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       rd_valid, prog_err, locked;

  otp_id_region #(
    .BYTE_W(8), .TOTAL_BYTES(32), .PRESET_BYTES(8), .ADDR_W(6), .PRESET_ID(PRESET)
  ) u0 (
    .clk(clk), .rst(rst), .prog_req(prog_req), .lock_req(lock_req), .rd_req(rd_req),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .prog_err(prog_err), .locked(locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0;
  int fails = 0;

  // Behavioural reference state
  int unsigned m_user[24];
  bit          m_lock = 1'b0;
  bit          e_valid, e_err;
  int unsigned e_data;

  // One clock: drive at a falling edge, predict, check at the next falling edge
  task automatic cyc(input bit r, input bit p, input bit l, input bit rd,
                     input int a, input int unsigned d, input string tag);
    rst = r; prog_req = p; lock_req = l; rd_req = rd;
    addr = 6'(a); wr_data = 8'(d);
    if (r) begin
      e_valid = 0; e_data = 0; e_err = 0;
    end else begin
      e_valid = rd && (a < 32);
      if (!e_valid)   e_data = 0;
      else if (a < 8) e_data = (PRESET >> (8 * a)) & 64'hFF;
      else            e_data = m_user[a-8];
      e_err = p && (a < 32) && ((a < 8) || m_lock);
      if (p && a >= 8 && a < 32 && !m_lock) m_user[a-8] = m_user[a-8] & (d & 8'hFF);
      if (l) m_lock = 1'b1;
    end
    @(negedge clk);
    tests++;
    if (rd_valid !== e_valid || rd_data !== 8'(e_data) ||
        prog_err !== e_err || locked !== m_lock) begin
      fails++;
      $display("FAIL %s addr=%0d: act valid=%0b data=%02h err=%0b lock=%0b exp valid=%0b data=%02h err=%0b lock=%0b",
               tag, a, rd_valid, rd_data, prog_err, locked,
               e_valid, 8'(e_data), e_err, m_lock);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 24; i++) m_user[i] = 8'hFF;
    rst = 1; prog_req = 0; lock_req = 0; rd_req = 0; addr = 0; wr_data = 0;
    @(negedge clk);
    // R10: reset state, requests under reset ignored (program byte 8 to 00)
    cyc(1, 1, 0, 1, 8, 8'h00, "R10");
    cyc(1, 0, 0, 0, 0, 0, "R10");
    // R1 preset bytes, R3 erased user bytes
    for (int a = 0; a < 8; a++)  cyc(0, 0, 0, 1, a, 0, "R1");
    for (int a = 8; a < 32; a++) cyc(0, 0, 0, 1, a, 0, "R3");
    // R2: preset program refused, byte unchanged
    cyc(0, 1, 0, 0, 3, 8'h00, "R2");
    cyc(0, 0, 0, 1, 3, 0, "R2");
    cyc(0, 1, 0, 1, 7, 8'h00, "R2");
    // R4: read same cycle as program sees old; next cycle sees new
    cyc(0, 1, 0, 1, 8, 8'hA5, "R4");
    cyc(0, 0, 0, 1, 8, 0, "R4");
    // R4: back-to-back programs to one offset compound
    cyc(0, 1, 0, 0, 8, 8'h0F, "R4");
    cyc(0, 1, 0, 1, 8, 8'h04, "R4");
    cyc(0, 0, 0, 1, 8, 0, "R4");
    // R11: programming with ones never restores a cleared bit
    cyc(0, 1, 0, 0, 9, 8'h5A, "R11");
    cyc(0, 1, 0, 0, 9, 8'hFF, "R11");
    cyc(0, 0, 0, 1, 9, 0, "R11");
    // R7: out-of-range offsets ignored
    cyc(0, 1, 0, 1, 40, 8'h00, "R7");
    cyc(0, 1, 0, 1, 63, 8'h00, "R7");
    cyc(0, 0, 0, 1, 31, 0, "R7");
    // R8: mixed stream of accepted, refused and idle programs
    for (int i = 0; i < 400; i++)
      cyc(0, bit'($urandom_range(0, 1)), 0, bit'($urandom_range(0, 1)),
          int'($urandom_range(0, 39)), $urandom_range(0, 255), "R8");
    for (int a = 8; a < 32; a++) cyc(0, 0, 0, 1, a, 0, "R4");
    // R6: program in same cycle as lock is still accepted
    cyc(0, 1, 1, 0, 31, 8'h00, "R6");
    cyc(0, 0, 0, 1, 31, 0, "R6");
    // R5/R6/R9: locked, refused programs, reads still work
    cyc(0, 1, 0, 0, 20, 8'h00, "R6");
    cyc(0, 0, 0, 1, 20, 0, "R9");
    cyc(0, 1, 0, 1, 2, 8'h00, "R9");
    // R5: lock survives reset
    cyc(1, 0, 0, 0, 0, 0, "R5");
    cyc(0, 1, 0, 0, 12, 8'h00, "R5");
    for (int i = 0; i < 200; i++)
      cyc(0, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
          int'($urandom_range(0, 39)), $urandom_range(0, 255), "R6");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule